// File: doc/BRIEF.md
# Parallel Bus Byte Receiver with Parity Check

This block pulls a counted run of bytes off an 8-bit parallel bus that carries a ninth parity line. It plays the initiating side of an interlocked handshake: it drives an active-low request line and watches an active-low acknowledge line from the far end. For every byte it waits for the acknowledge line to be idle (high), pulls the request low, and waits for the far end to pull acknowledge low. In the clock cycle where it sees acknowledge low, it lets request go high again and latches the nine bus lines on that same edge.

Each latched byte goes out on a ready/valid stream together with a per-byte parity verdict. The block only starts a new byte when its one-entry output slot is empty or being drained in that cycle, so back-pressure on the stream slows the bus. A parity error raises a sticky interrupt flag, and data keeps flowing. Software clears the flag by writing one to a clear input. A transfer starts with a byte count, and it ends with a one-cycle done pulse after that many bytes have been received.

The acknowledge line comes from off-chip and is passed through a synchronizer before the handshake logic uses it. The reset input is asserted asynchronously and released synchronously inside the block.

Top module: `pbus_rx`

## Requirements
- R1: While reset is held and right after it is released, `req_n` is 1, and `out_valid`, `irq`, `done` and `busy` are all 0.
- R2: A `start` pulse while idle loads `count_in` and raises `busy`. A `start` pulse while `busy` is 1 is ignored: the byte count of the running transfer is not changed.
- R3: `req_n` is driven low only when the synchronized acknowledge is high. While `ack_n` is held low, no request is issued.
- R4: Once `req_n` is low, it stays low until the synchronized acknowledge is low. On that edge `req_n` returns to 1 and `bus_data`/`bus_par` are captured. This happens exactly SYNC_STAGES+1 clock edges after `ack_n` falls (3 with the defaults).
- R5: A new request is issued only when the output slot is empty or is being taken in that cycle (`out_valid`=0 or `out_ready`=1). With `out_ready` held at 0, at most one byte is fetched.
- R6: Each captured byte appears on `out_data` (`bus_data` bit i on `out_data` bit i) while `out_valid` is 1. It is held until `out_ready` is 1. Bytes appear in bus order.
- R7: `out_par_ok` is 1 when the XOR of `bus_data[7:0]` and `bus_par` is 1 (odd parity), and 0 otherwise. A byte with bad parity sets `irq` and is still delivered.
- R8: `irq` stays 1 until `irq_clr` is 1 in a cycle. It is then 0 from the next cycle on, unless a new parity error is captured in the same cycle.
- R9: After the loaded number of bytes has been captured, `done` is 1 for exactly one cycle and `busy` returns to 0. A count of 0 gives a single `done` pulse with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (ignored while busy) |
| count_in | input | CNT_W | Number of bytes to receive |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at end of transfer |
| bus_data | input | DATA_W | Parallel bus data lines |
| bus_par | input | 1 | Parallel bus parity line |
| ack_n | input | 1 | Acknowledge from far end, active low, asynchronous |
| req_n | output | 1 | Request to far end, active low |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts byte |
| out_data | output | DATA_W | Received byte |
| out_par_ok | output | 1 | 1 = parity good, 0 = parity error |
| irq | output | 1 | Sticky parity-error flag |
| irq_clr | input | 1 | Write-one-to-clear for `irq` |

## Verification
The handshake assertions assume that the far end keeps to the interlock. It pulls acknowledge low only while request is low, releases it only after request has returned high, and holds the bus lines steady from before its acknowledge until request rises. The bench's far-end model follows that order on every byte, with random delays of a few cycles at each step. The stream check assumes `out_ready` may change in any cycle, so the bench picks it at random, holds it low for a long stretch, or holds it high. Parity is chosen to be good or bad on purpose for each byte.

// File: rtl/pbr_pkg.sv
package pbr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_WAIT_HI = 2'd1,
    ST_REQ     = 2'd2
  } hs_state_t;
endpackage

// File: rtl/pbr_rst_sync.sv
module pbr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/pbr_sync.sv
module pbr_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] ff_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) ff_q[0] <= RST_VAL;
          else        ff_q[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) ff_q[g] <= RST_VAL;
          else        ff_q[g] <= ff_q[g-1];
        end
      end
    end
  endgenerate

  assign q_sync = ff_q[STAGES-1];
endmodule

// File: rtl/pbr_parity.sv
module pbr_parity #(
  parameter int DATA_W     = 8,
  parameter bit ODD_PARITY = 1'b1
) (
  input  logic [DATA_W-1:0] data,
  input  logic              par,
  output logic              ok
);
  generate
    if (ODD_PARITY) begin : g_odd
      assign ok = ^{par, data};
    end else begin : g_even
      assign ok = ~^{par, data};
    end
  endgenerate
endmodule

// File: rtl/pbr_hs_fsm.sv
module pbr_hs_fsm
  import pbr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] count_in,
  input  logic             ack_s,
  input  logic             slot_free,
  output logic             req_n,
  output logic             capture,
  output logic             busy,
  output logic             done
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  hs_state_t        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             req_q, req_d;
  logic             done_q, done_d;
  logic             cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    req_d   = req_q;
    done_d  = 1'b0;
    capture = 1'b0;
    cnt_en  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (count_in == '0) begin
            done_d = 1'b1;
          end else begin
            cnt_d   = count_in;
            cnt_en  = 1'b1;
            state_d = ST_WAIT_HI;
          end
        end
      end
      ST_WAIT_HI: begin
        if (ack_s && slot_free) begin
          req_d   = 1'b0;
          state_d = ST_REQ;
        end
      end
      ST_REQ: begin
        if (!ack_s) begin
          req_d   = 1'b1;
          capture = 1'b1;
          cnt_d   = cnt_q - CNT_ONE;
          cnt_en  = 1'b1;
          if (cnt_q == CNT_ONE) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            state_d = ST_WAIT_HI;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      req_q   <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      req_q   <= req_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign req_n = req_q;
  assign busy  = (state_q != ST_IDLE);
  assign done  = done_q;

  // R3: request only asserted after synchronized acknowledge was high
  p_req_on_ack_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_n) |-> $past(ack_s));

  // R4: request released only after synchronized acknowledge was low
  p_req_off_ack_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_n) |-> !$past(ack_s));

  // R4: request held low while acknowledge stays high
  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_n && ack_s) |=> !req_n);

  // R9: done is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/pbus_rx.sv
module pbus_rx #(
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter bit ODD_PARITY  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  count_in,
  output logic              busy,
  output logic              done,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              bus_par,
  input  logic              ack_n,
  output logic              req_n,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_par_ok,
  output logic              irq,
  input  logic              irq_clr
);
  logic              rst_i_n;
  logic              ack_s;
  logic              slot_free;
  logic              capture;
  logic              par_ok;
  logic              valid_q, valid_d;
  logic [DATA_W-1:0] data_q;
  logic              ok_q;
  logic              irq_q, irq_d;

  pbr_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  pbr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ack_sync (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .d_async (ack_n),
    .q_sync  (ack_s)
  );

  pbr_parity #(.DATA_W(DATA_W), .ODD_PARITY(ODD_PARITY)) u_parity (
    .data (bus_data),
    .par  (bus_par),
    .ok   (par_ok)
  );

  assign slot_free = !valid_q || out_ready;

  pbr_hs_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .start     (start),
    .count_in  (count_in),
    .ack_s     (ack_s),
    .slot_free (slot_free),
    .req_n     (req_n),
    .capture   (capture),
    .busy      (busy),
    .done      (done)
  );

  // output slot and sticky flag: next-state logic
  always_comb begin
    valid_d = valid_q;
    if (valid_q && out_ready) valid_d = 1'b0;
    if (capture)              valid_d = 1'b1;
    irq_d = irq_q;
    if (irq_clr)              irq_d = 1'b0;
    if (capture && !par_ok)   irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      valid_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      irq_q   <= irq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      data_q <= '0;
      ok_q   <= 1'b0;
    end else if (capture) begin
      data_q <= bus_data;
      ok_q   <= par_ok;
    end
  end

  assign out_valid  = valid_q;
  assign out_data   = data_q;
  assign out_par_ok = ok_q;
  assign irq        = irq_q;

  // R5: a request is only issued when the output slot can take the byte
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_i_n)
    $fell(req_n) |-> $past(!out_valid || out_ready));

  // R6: a held byte does not change until it is taken
  p_hold_data_r6: assert property (@(posedge clk) disable iff (!rst_i_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_par_ok)));

  // R7: a bad-parity capture raises the flag
  p_irq_set_r7: assert property (@(posedge clk) disable iff (!rst_i_n)
    (capture && !par_ok) |=> irq);

  // R8: flag is sticky without a clear
  p_irq_sticky_r8: assert property (@(posedge clk) disable iff (!rst_i_n)
    (irq && !irq_clr) |=> irq);

  // R8: a clear with no new error drops the flag
  p_irq_clear_r8: assert property (@(posedge clk) disable iff (!rst_i_n)
    (irq_clr && !(capture && !par_ok)) |=> !irq);
endmodule

// File: tb/test_pbus_rx.sv
module test_pbus_rx;
  localparam int DW  = 8;
  localparam int CW  = 16;
  localparam int LAT = 3; // SYNC_STAGES + 1

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [CW-1:0] count_in;
  logic          busy, done;
  logic [DW-1:0] bus_data;
  logic          bus_par;
  logic          ack_n, ack_t, hold_low;
  logic          req_n;
  logic          out_valid, out_ready;
  logic [DW-1:0] out_data;
  logic          out_par_ok;
  logic          irq, irq_clr;

  int checks = 0, errors = 0;
  int done_cnt = 0, req_falls = 0, pops = 0;
  int rdy_mode = 0;
  bit exp_irq = 1'b0;
  bit finished = 1'b0;
  logic [8:0] tx_q[$];
  logic [8:0] exp_q[$];

  always #4 clk = ~clk;

  assign ack_n = ack_t & ~hold_low;

  pbus_rx i_pbus_rx (
    .clk(clk), .rst_n(rst_n), .start(start), .count_in(count_in),
    .busy(busy), .done(done), .bus_data(bus_data), .bus_par(bus_par),
    .ack_n(ack_n), .req_n(req_n), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_par_ok(out_par_ok), .irq(irq), .irq_clr(irq_clr)
  );

  function automatic bit odd_ok(input logic [8:0] w);
    return ^w;
  endfunction

  function automatic logic [8:0] make_word(input bit bad);
    logic [7:0] d;
    logic       p;
    d = 8'($urandom);
    p = bad ? (^d) : ~(^d);
    return {p, d};
  endfunction

  task automatic chk(input bit cond, input string tag, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge req_n) req_falls++;

  // far-end model: interlocked handshake with random delays
  initial begin
    ack_t    = 1'b1;
    bus_data = '0;
    bus_par  = 1'b0;
    forever begin
      int lat;
      @(negedge req_n);
      repeat ($urandom_range(0, 3)) @(posedge clk);
      #1;
      if (tx_q.size() > 0) {bus_par, bus_data} = tx_q.pop_front();
      else                 {bus_par, bus_data} = 9'h0;
      repeat (1 + $urandom_range(0, 2)) @(posedge clk);
      #1 ack_t = 1'b0;
      lat = 0;
      for (int i = 1; i <= 10; i++) begin
        @(posedge clk);
        #1;
        if (req_n) begin lat = i; break; end
      end
      chk(lat == LAT, "R4 request release latency", lat, LAT);
      repeat ($urandom_range(0, 3)) @(posedge clk);
      #1 ack_t = 1'b1;
    end
  end

  // stream sink and done counter
  initial out_ready = 1'b0;
  always @(negedge clk) begin
    if (done) done_cnt++;
    case (rdy_mode)
      0:       out_ready = 1'b1;
      1:       out_ready = ($urandom_range(0, 99) < 60);
      default: out_ready = 1'b0;
    endcase
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6 unexpected output byte", out_data, -1);
      end else begin
        logic [8:0] w;
        w = exp_q.pop_front();
        pops++;
        chk(out_data == w[7:0], "R6 output byte", out_data, w[7:0]);
        chk(out_par_ok == odd_ok(w), "R7 parity verdict", out_par_ok, odd_ok(w));
        if (!odd_ok(w)) exp_irq = 1'b1;
      end
    end
  end

  task automatic pulse_start(input int n);
    @(negedge clk);
    start    = 1'b1;
    count_in = CW'(n);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic queue_bytes(input int n, input int bad_pct);
    for (int i = 0; i < n; i++) begin
      logic [8:0] w;
      w = make_word($urandom_range(0, 99) < bad_pct);
      tx_q.push_back(w);
      exp_q.push_back(w);
    end
  endtask

  task automatic wait_end(input int base_done);
    int t;
    t = 0;
    while (!(done_cnt > base_done && exp_q.size() == 0 && !out_valid) && t < 20000) begin
      @(negedge clk);
      t++;
    end
    @(negedge clk);
    chk(done_cnt == base_done + 1, "R9 one done pulse per transfer", done_cnt - base_done, 1);
    chk(!busy, "R9 busy low after transfer", busy, 0);
  endtask

  task automatic check_and_clear_irq();
    chk(irq == exp_irq, "R7 irq after transfer", irq, exp_irq);
    @(negedge clk) irq_clr = 1'b1;
    @(negedge clk) irq_clr = 1'b0;
    chk(irq == 1'b0, "R8 irq cleared by irq_clr", irq, 0);
    exp_irq = 1'b0;
  endtask

  initial begin
    int seed_v, d0, r0, p0;
    seed_v   = $urandom(32'd20240917);
    rst_n    = 1'b0;
    start    = 1'b0;
    count_in = '0;
    irq_clr  = 1'b0;
    hold_low = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(req_n == 1'b1, "R1 req_n in reset", req_n, 1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(req_n == 1'b1, "R1 req_n after reset", req_n, 1);
    chk(!out_valid, "R1 out_valid after reset", out_valid, 0);
    chk(!irq, "R1 irq after reset", irq, 0);
    chk(!done, "R1 done after reset", done, 0);
    chk(!busy, "R1 busy after reset", busy, 0);

    // R9: zero count
    d0 = done_cnt; r0 = req_falls;
    pulse_start(0);
    repeat (10) @(negedge clk);
    chk(done_cnt == d0 + 1, "R9 zero count done", done_cnt - d0, 1);
    chk(req_falls == r0, "R9 zero count no request", req_falls - r0, 0);

    // R3: acknowledge stuck low blocks the request
    rdy_mode = 0;
    hold_low = 1'b1;
    r0 = req_falls; d0 = done_cnt;
    queue_bytes(2, 0);
    pulse_start(2);
    repeat (30) @(negedge clk);
    chk(req_falls == r0, "R3 no request while ack low", req_falls - r0, 0);
    chk(busy, "R2 busy after start", busy, 1);
    hold_low = 1'b0;
    wait_end(d0);
    chk(req_falls == r0 + 2, "R3 requests after ack release", req_falls - r0, 2);

    // R5: back-pressure holds off further requests
    rdy_mode = 2;
    r0 = req_falls; d0 = done_cnt;
    queue_bytes(3, 0);
    pulse_start(3);
    repeat (60) @(negedge clk);
    chk(req_falls == r0 + 1, "R5 one byte fetched under back-pressure", req_falls - r0, 1);
    chk(out_valid, "R5 byte held valid", out_valid, 1);
    rdy_mode = 1;
    wait_end(d0);
    check_and_clear_irq();

    // R7/R8: single bad-parity byte, sticky flag
    rdy_mode = 0;
    d0 = done_cnt;
    begin
      logic [8:0] w;
      w = make_word(1'b1);
      tx_q.push_back(w);
      exp_q.push_back(w);
    end
    pulse_start(1);
    wait_end(d0);
    chk(irq == 1'b1, "R7 irq set by bad parity", irq, 1);
    repeat (20) @(negedge clk);
    chk(irq == 1'b1, "R8 irq sticky", irq, 1);
    check_and_clear_irq();

    // R2: start while busy is ignored
    rdy_mode = 1;
    r0 = req_falls; d0 = done_cnt; p0 = pops;
    queue_bytes(4, 0);
    pulse_start(4);
    @(negedge req_n);
    pulse_start(9);
    wait_end(d0);
    repeat (40) @(negedge clk);
    chk(pops == p0 + 4, "R2 count unchanged by start while busy", pops - p0, 4);
    chk(req_falls == r0 + 4, "R2 request count", req_falls - r0, 4);

    // random transfers
    for (int k = 0; k < 20; k++) begin
      int n;
      n = $urandom_range(1, 12);
      rdy_mode = (k % 3 == 0) ? 0 : 1;
      d0 = done_cnt; p0 = pops;
      queue_bytes(n, 20);
      pulse_start(n);
      wait_end(d0);
      chk(pops == p0 + n, "R6 byte count delivered", pops - p0, n);
      check_and_clear_irq();
    end

    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule